// File: doc/BRIEF.md
# Temporal Change Detector for Photon-Count Frames

This block looks for a sudden, sustained rise in light at any pixel of a small photon-count imager. Every frame is an array of unsigned 8-bit transition counts, one per pixel. The detector compares the four most recent frames of each pixel and produces three successive frame-to-frame differences. It removes a programmable mean offset from each difference and tests each result against a threshold, which is a small multiplier times a deviation figure. A pixel raises an event only if all three tests pass.

The newest frame is not copied into the block. The frame builder keeps it in its own synchronous-read memory. When that frame is complete, the builder sends a one-cycle ready pulse. The detector then walks the pixels one at a time. It reads each new count through an address/data port and reads the three older counts from its internal history. It then writes the new count over the oldest one. So the history always holds the three frames that came before the next one. Handling one pixel at a time keeps the datapath down to a single set of three comparators.

At the end of each scan the block pulses a done flag. It also updates a detection flag and the index of the lowest-numbered pixel that fired, and holds both until the next scan ends. The mean, deviation and multiplier are static inputs: they do not adapt.

Top module: `frame_change_detector`

## Requirements
- R1: While reset is applied and after it is released, until the first scan ends, `det_flag` is 0, `det_idx` is 0, `scan_done` is 0 and `cur_addr` is 0.
- R2: A `frame_rdy` pulse sampled while the block is idle starts a scan. The scan visits pixels 0 to NPIX-1 in increasing order. Each pixel takes two cycles, with `cur_addr` held at that index for both. `cur_data` is taken one cycle after the address is presented. `scan_done` is high for exactly one cycle, 2*NPIX cycles after the edge that sampled `frame_rdy`.
- R3: Each difference is formed as newer count minus older count at full signed width (range -255 to +255 for 8-bit counts), with no wrap-around.
- R4: With the four frames of a pixel ordered y1 (oldest) to y4 (newest), the pixel fires when (y2-y1)-mu, (y3-y2)-mu and (y4-y3)-mu are all strictly greater than c_mult*sigma. `mu` is two's complement; `sigma` and `c_mult` are unsigned. Equality does not fire.
- R5: At the end of a scan, `det_flag` is 1 exactly when some pixel fired, and `det_idx` is the lowest firing index, or 0 when none fired. Both hold their value until the next `scan_done`.
- R6: The first three scans after reset report `det_flag` = 0 whatever the data, because fewer than four frames exist. From the fourth scan on, detection is live.
- R7: A `frame_rdy` pulse that arrives during a scan, including on the cycle of the last pixel's evaluation, is ignored. It does not restart or lengthen the scan, it produces no extra `scan_done`, and it does not advance the frame history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_rdy | input | 1 | One-cycle pulse: a new frame is complete in the builder's memory |
| mu | input | MU_W | Signed mean offset removed from each difference |
| sigma | input | SG_W | Unsigned deviation figure |
| c_mult | input | C_W | Unsigned multiplier applied to `sigma` |
| cur_addr | output | $clog2(ROWS*COLS) | Pixel index presented to the frame builder's memory |
| cur_data | input | PIX_W | Count returned for `cur_addr` one cycle later |
| scan_done | output | 1 | One-cycle pulse at the end of every scan |
| det_flag | output | 1 | Some pixel fired in the last completed scan |
| det_idx | output | $clog2(ROWS*COLS) | Lowest firing pixel index of that scan |

## Verification
Two events can land on the same clock edge: a new frame-ready pulse, and the evaluation of the last pixel, which closes the scan and rotates the history. The bench provokes this by raising `frame_rdy` so that it is sampled on that exact edge. It also raises it in the middle of a scan. It then judges three things against its own four-frame model. There must be exactly one done pulse per accepted frame. The scan length must be unchanged. The results of the frames that follow must show that the history moved forward only once.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_EV   = 2'd2
  } scan_st_t;

  // History banks rotate modulo 3
  function automatic logic [1:0] bank_after(input logic [1:0] b);
    return (b == 2'd2) ? 2'd0 : b + 2'd1;
  endfunction

endpackage

// File: rtl/fcd_hist.sv
module fcd_hist #(
  parameter int NPIX  = 1024,
  parameter int PIX_W = 8,
  localparam int AW   = $clog2(NPIX)
) (
  input  logic                 clk,
  input  logic                 rst_i_n,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  input  logic                 wr_en,
  input  logic [1:0]           wr_bank,
  input  logic [AW-1:0]        wr_addr,
  input  logic [PIX_W-1:0]     wr_data,
  output logic [3*PIX_W-1:0]   rd_q
);

  for (genvar b = 0; b < 3; b++) begin : g_bank
    logic [PIX_W-1:0] mem [NPIX];
    logic [PIX_W-1:0] q;

    always_ff @(posedge clk) begin
      if (rd_en) begin
        q <= mem[rd_addr];
      end
      if (wr_en && (wr_bank == 2'(b))) begin
        mem[wr_addr] <= wr_data;
      end
    end

    assign rd_q[b*PIX_W +: PIX_W] = q;
  end

  // R2: the read of a pixel and the write-back of the same pixel use separate cycles
  p_port_excl_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(rd_en && wr_en));

endmodule

// File: rtl/fcd_lane.sv
module fcd_lane #(
  parameter int PIX_W = 8,
  parameter int MU_W  = 9,
  parameter int CMP_W = 13
) (
  input  logic [PIX_W-1:0]        y_prev,
  input  logic [PIX_W-1:0]        y_next,
  input  logic signed [MU_W-1:0]  mu,
  input  logic signed [CMP_W-1:0] thr,
  output logic                    fire
);

  logic signed [CMP_W-1:0] diff_s;
  logic signed [CMP_W-1:0] adj_s;

  always_comb begin
    diff_s = $signed({{(CMP_W-PIX_W){1'b0}}, y_next})
           - $signed({{(CMP_W-PIX_W){1'b0}}, y_prev});
    adj_s  = diff_s - $signed({{(CMP_W-MU_W){mu[MU_W-1]}}, mu});
    fire   = adj_s > thr;
  end

endmodule

// File: rtl/frame_change_detector.sv
module frame_change_detector #(
  parameter int ROWS  = 32,
  parameter int COLS  = 32,
  parameter int PIX_W = 8,
  parameter int MU_W  = 9,
  parameter int SG_W  = 8,
  parameter int C_W   = 4,
  localparam int NPIX = ROWS * COLS,
  localparam int AW   = $clog2(NPIX)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_rdy,
  input  logic signed [MU_W-1:0] mu,
  input  logic [SG_W-1:0]        sigma,
  input  logic [C_W-1:0]         c_mult,
  output logic [AW-1:0]          cur_addr,
  input  logic [PIX_W-1:0]       cur_data,
  output logic                   scan_done,
  output logic                   det_flag,
  output logic [AW-1:0]          det_idx
);

  import fcd_pkg::*;

  localparam int TW    = SG_W + C_W;
  localparam int DW    = PIX_W + 1;
  localparam int AJ_W  = ((DW > MU_W) ? DW : MU_W) + 1;
  localparam int CMP_W = ((AJ_W > TW) ? AJ_W : TW) + 1;
  localparam logic [AW-1:0] LAST = AW'(NPIX - 1);
  localparam logic [1:0]    FULL = 2'd3;

  // reset: asserted asynchronously, released on the clock
  logic rs0, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0     <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rs0     <= 1'b1;
      rst_i_n <= rs0;
    end
  end

  scan_st_t        st, st_n;
  logic [AW-1:0]   addr, addr_n;
  logic [1:0]      ptr, ptr_n;
  logic [1:0]      fill, fill_n;
  logic            hit, hit_n;
  logic [AW-1:0]   first, first_n;
  logic            flag_n, done_n;
  logic [AW-1:0]   idx_n;

  // history and threshold datapath
  logic [3*PIX_W-1:0]      rd_q;
  logic [PIX_W-1:0]        yv [4];
  logic [1:0]              b1, b2;
  logic [TW-1:0]           prod;
  logic signed [CMP_W-1:0] thr;
  logic [2:0]              lane_fire;
  logic                    pix_fire;

  fcd_hist #(.NPIX(NPIX), .PIX_W(PIX_W)) u_hist (
    .clk     (clk),
    .rst_i_n (rst_i_n),
    .rd_en   (st == ST_RD),
    .rd_addr (addr),
    .wr_en   (st == ST_EV),
    .wr_bank (ptr),
    .wr_addr (addr),
    .wr_data (cur_data),
    .rd_q    (rd_q)
  );

  always_comb begin
    b1    = bank_after(ptr);
    b2    = bank_after(b1);
    yv[0] = rd_q[ptr*PIX_W +: PIX_W];
    yv[1] = rd_q[b1*PIX_W  +: PIX_W];
    yv[2] = rd_q[b2*PIX_W  +: PIX_W];
    yv[3] = cur_data;
    prod  = TW'(c_mult) * TW'(sigma);
    thr   = $signed({{(CMP_W-TW){1'b0}}, prod});
  end

  for (genvar k = 0; k < 3; k++) begin : g_lane
    fcd_lane #(.PIX_W(PIX_W), .MU_W(MU_W), .CMP_W(CMP_W)) u_lane (
      .y_prev (yv[k]),
      .y_next (yv[k+1]),
      .mu     (mu),
      .thr    (thr),
      .fire   (lane_fire[k])
    );
  end

  assign pix_fire = (&lane_fire) && (fill == FULL);

  // next-state
  always_comb begin
    st_n    = st;
    addr_n  = addr;
    ptr_n   = ptr;
    fill_n  = fill;
    hit_n   = hit;
    first_n = first;
    flag_n  = det_flag;
    idx_n   = det_idx;
    done_n  = 1'b0;
    case (st)
      ST_IDLE: begin
        if (frame_rdy) begin
          st_n    = ST_RD;
          addr_n  = '0;
          hit_n   = 1'b0;
          first_n = '0;
        end
      end
      ST_RD: st_n = ST_EV;
      ST_EV: begin
        if (pix_fire && !hit) begin
          hit_n   = 1'b1;
          first_n = addr;
        end
        if (addr == LAST) begin
          st_n   = ST_IDLE;
          addr_n = '0;
          ptr_n  = bank_after(ptr);
          fill_n = (fill == FULL) ? fill : fill + 2'd1;
          done_n = 1'b1;
          flag_n = hit_n;
          idx_n  = first_n;
        end else begin
          st_n   = ST_RD;
          addr_n = addr + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st        <= ST_IDLE;
      addr      <= '0;
      ptr       <= '0;
      fill      <= '0;
      hit       <= 1'b0;
      first     <= '0;
      det_flag  <= 1'b0;
      det_idx   <= '0;
      scan_done <= 1'b0;
    end else begin
      st        <= st_n;
      addr      <= addr_n;
      ptr       <= ptr_n;
      fill      <= fill_n;
      hit       <= hit_n;
      first     <= first_n;
      scan_done <= done_n;
      if (done_n) begin
        det_flag <= flag_n;
        det_idx  <= idx_n;
      end
    end
  end

  assign cur_addr = addr;

  // R2: done lasts a single cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    scan_done |=> !scan_done);

  // R2: pixels are visited in ascending order
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st == ST_EV && addr != LAST) |=> (addr == $past(addr) + 1'b1));

  // R5: results only move on the done edge
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    !scan_done |-> ($stable(det_flag) && $stable(det_idx)));

  // R6: no event before the history is full
  p_fill_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    det_flag |-> (fill == FULL));

  // R7: a ready pulse inside a scan does not disturb it
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st == ST_RD && frame_rdy) |=> (st == ST_EV && addr == $past(addr)));

endmodule

// File: tb/frame_change_detector_bench.sv
`timescale 1ns/1ps
module frame_change_detector_bench;

  localparam int ROWS = 2;
  localparam int COLS = 4;
  localparam int NPIX = ROWS * COLS;
  localparam int AW   = $clog2(NPIX);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              frame_rdy;
  logic signed [8:0] mu;
  logic [7:0]        sigma;
  logic [3:0]        c_mult;
  logic [AW-1:0]     cur_addr;
  logic [7:0]        cur_data;
  logic              scan_done;
  logic              det_flag;
  logic [AW-1:0]     det_idx;

  always #2 clk = ~clk;

  frame_change_detector #(.ROWS(ROWS), .COLS(COLS)) u_frame_change_detector (
    .clk(clk), .rst_n(rst_n), .frame_rdy(frame_rdy), .mu(mu), .sigma(sigma),
    .c_mult(c_mult), .cur_addr(cur_addr), .cur_data(cur_data),
    .scan_done(scan_done), .det_flag(det_flag), .det_idx(det_idx)
  );

  // frame builder memory model: synchronous read
  logic [7:0] ext_mem [NPIX];
  always @(posedge clk) cur_data <= ext_mem[cur_addr];

  int cyc = 0;
  int ndone = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (scan_done) ndone <= ndone + 1;
  end

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int h [4][NPIX];
  int nfr = 0;
  logic [7:0] nxt [NPIX];
  int mu_i, sg_i, c_i;
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int m, input int s, input int c);
    mu_i = m; sg_i = s; c_i = c;
    mu = m[8:0]; sigma = s[7:0]; c_mult = c[3:0];
  endtask

  function automatic bit px_fire(input int p);
    for (int k = 0; k < 3; k++) begin
      if ((h[k+1][p] - h[k][p]) - mu_i <= c_i * sg_i) return 1'b0;
    end
    return 1'b1;
  endfunction

  // mode 0: plain, 1: extra ready mid-scan, 2: extra ready on last evaluation
  task automatic run_frame(input string req, input int mode);
    int c0, k, nd0, exp_i, badaddr;
    bit exp_f;
    for (int p = 0; p < NPIX; p++) ext_mem[p] = nxt[p];
    for (int s = 0; s < 3; s++)
      for (int p = 0; p < NPIX; p++) h[s][p] = h[s+1][p];
    for (int p = 0; p < NPIX; p++) h[3][p] = nxt[p];
    nfr++;
    exp_f = 0; exp_i = 0;
    if (nfr >= 4) begin
      for (int p = 0; p < NPIX; p++) begin
        if (!exp_f && px_fire(p)) begin exp_f = 1; exp_i = p; end
      end
    end
    nd0 = ndone;
    @(negedge clk) frame_rdy = 1'b1;
    @(negedge clk) frame_rdy = 1'b0;
    c0 = cyc; k = 0; badaddr = 0;
    while (!scan_done && k < 4*NPIX) begin
      if (int'(cur_addr) != k/2) badaddr++;
      if (mode == 1 && k == 4) frame_rdy = 1'b1;
      if (mode == 1 && k == 5) frame_rdy = 1'b0;
      if (mode == 2 && k == 2*NPIX-1) frame_rdy = 1'b1;
      @(negedge clk);
      k = cyc - c0;
    end
    frame_rdy = 1'b0;
    check(k == 2*NPIX, "R2", "scan length", k, 2*NPIX);
    check(badaddr == 0, "R2", "address order errors", badaddr, 0);
    check(det_flag == exp_f, req, "det_flag", det_flag, exp_f);
    check(int'(det_idx) == exp_i, req, "det_idx", det_idx, exp_i);
    repeat (2*NPIX + 3) @(negedge clk);
    check(ndone == nd0 + 1, "R7", "done pulses per frame", ndone - nd0, 1);
    check(det_flag == exp_f && int'(det_idx) == exp_i, "R5", "held result",
          {det_flag, 8'(det_idx)}, {exp_f, 8'(exp_i)});
  endtask

  task automatic rand_frame();
    for (int p = 0; p < NPIX; p++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      nxt[p] = seed[23:16];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_rdy = 1'b0; set_cfg(0, 0, 0);
    for (int p = 0; p < NPIX; p++) ext_mem[p] = 8'd0;
    for (int s = 0; s < 4; s++) for (int p = 0; p < NPIX; p++) h[s][p] = 0;
    repeat (3) @(negedge clk);
    check(det_flag == 0 && det_idx == 0 && scan_done == 0 && cur_addr == 0,
          "R1", "outputs in reset", {det_flag, scan_done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(det_flag == 0, "R1", "det_flag after reset", det_flag, 0);
    check(det_idx == 0, "R1", "det_idx after reset", det_idx, 0);
    check(scan_done == 0, "R1", "scan_done after reset", scan_done, 0);
    check(cur_addr == 0, "R1", "cur_addr after reset", cur_addr, 0);

    // R6: every pixel would pass, yet the first three scans stay quiet
    set_cfg(-256, 0, 0);
    for (int f = 0; f < 3; f++) begin rand_frame(); run_frame("R6", 0); end
    rand_frame(); run_frame("R5", 0);

    // R4 sweep over configurations and data, with R7 collisions
    for (int f = 0; f < 160; f++) begin
      set_cfg(((f * 13) % 61) - 40, (f * 7) % 40, f % 16);
      rand_frame();
      run_frame("R4", f % 3);
    end

    // R4 equality boundary: x = 10, mu = 2, thr = 8 -> no fire; mu = 1 -> fire at 5
    set_cfg(2, 4, 2);
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < NPIX; p++) nxt[p] = 8'd100;
      nxt[5] = 8'(50 + 10 * k);
      run_frame("R4", 0);
    end
    check(det_flag == 0, "R4", "equal to threshold fired", det_flag, 0);
    set_cfg(1, 4, 2);
    for (int p = 0; p < NPIX; p++) nxt[p] = 8'd100;
    nxt[5] = 8'd90;
    run_frame("R4", 0);
    check(det_flag == 1 && det_idx == 5, "R4", "just above threshold idx",
          det_idx, 5);

    // R3 full-width difference: pixel 3 = 0,1,2,255 passes only without wrap
    set_cfg(-100, 100, 1);
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < NPIX; p++) nxt[p] = 8'd9;
      nxt[3] = (k == 3) ? 8'd255 : 8'(k);
      run_frame("R3", 0);
    end
    check(det_flag == 1 && det_idx == 3, "R3", "large difference idx", det_idx, 3);

    // R5 lowest index wins: pixels 2 and 6 both rise
    set_cfg(0, 5, 1);
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < NPIX; p++) nxt[p] = 8'd40;
      nxt[2] = 8'(20 * k);
      nxt[6] = 8'(30 * k);
      run_frame("R5", (k == 3) ? 2 : 0);
    end
    check(det_flag == 1 && det_idx == 2, "R5", "first firing index", det_idx, 2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule